// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block generates the serial clock for an I2C master from a fast reference clock. A programmable prescaler divides the reference clock into base ticks. Each SCL period has a low phase and a high phase. Their lengths in base ticks come from a two-bit ratio code that selects a balanced split or one of two asymmetric splits. The SCL output is open-drain: the block only ever pulls the line low or lets it go.

The high phase does not start counting until the returned SCL level, after a two-flop synchronizer, is seen high. A slave that holds the line low, or a slow rising edge, therefore lengthens the period instead of cutting the high time short. Three one-cycle strobes go to a byte engine: one when SCL is pulled low, one halfway through the low phase (the safe moment to change SDA), and one when SCL is released. The prescale value and ratio code are captured at the start of every low phase, so each period is built from a single configuration.

Top module: `scl_clock_gen`

## Requirements
- R1: During and right after reset, `scl_drive_low` is 0 and all three strobes are 0.
- R2: Each low phase keeps `scl_drive_low` at 1 for exactly Nlow × (prescale + 1) reference cycles.
- R3: When the bus follows the drive with no extra hold, each high phase lasts Nhigh × (prescale + 1) + 2 reference cycles. The extra 2 cycles are the synchronizer latency before counting starts.
- R4: The ratio code sets Nlow:Nhigh as follows: 0 gives 4:4, 1 gives 6:3, 2 gives 11:3, and 3 falls back to 4:4.
- R5: If `scl_in` is held low for S cycles after release, the high phase grows by exactly S cycles, because the high count holds while the synchronized line reads low.
- R6: When `enable` is 0, SCL is released from the next cycle, no strobes fire and the counters clear. When `enable` rises, the first low phase begins on the next clock edge, with `tick_fall` set.
- R7: `tick_fall` is high for only the first cycle of each low phase, and `tick_rise` for only the first cycle of each high phase. At most one strobe is high in any cycle.
- R8: `tick_mid_low` fires once per low phase, (Nlow/2, rounded down) × (prescale + 1) cycles after the cycle in which `tick_fall` is high.
- R9: A change of `prescale` or `ratio_mode` during a period takes effect only from the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; 0 releases SCL and clears counters |
| prescale | input | PRE_W | Base tick every prescale+1 reference cycles |
| ratio_mode | input | 2 | Low:high split code (R4) |
| scl_in | input | 1 | Sampled SCL bus level, asynchronous |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 leaves it released (high-Z) |
| tick_fall | output | 1 | Strobe in the first cycle of a low phase |
| tick_mid_low | output | 1 | Strobe at the middle of a low phase |
| tick_rise | output | 1 | Strobe in the first cycle of a high phase |

## Verification
The bench builds the block with a four-bit prescale field and the default two synchronizer stages. This keeps every period short enough to sweep prescale values 0 to 3 across all four ratio codes, each with and without a three-cycle slave stretch, and to check every phase length and strobe position against arithmetic expectations. The small width also puts a mid-period configuration change and a disable in the middle of a low phase within easy reach.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    RATIO_EVEN = 2'd0,
    RATIO_SKEW = 2'd1,
    RATIO_QUICK = 2'd2
  } ratio_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  function automatic logic [CNT_W-1:0] low_ticks(input logic [1:0] code);
    case (code)
      RATIO_SKEW:  low_ticks = CNT_W'(6);
      RATIO_QUICK: low_ticks = CNT_W'(11);
      default:     low_ticks = CNT_W'(4);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] high_ticks(input logic [1:0] code);
    case (code)
      RATIO_SKEW:  high_ticks = CNT_W'(3);
      RATIO_QUICK: high_ticks = CNT_W'(3);
      default:     high_ticks = CNT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hold,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = !clear && !hold && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (hold)    cnt <= cnt;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + PRE_W'(1);
  end

  // A base tick always restarts the division from zero (R2).
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [1:0]       ratio_mode,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             tick_fall,
  output logic             tick_mid_low,
  output logic             tick_rise
);

  phase_e           phase;
  logic [CNT_W-1:0] ph_cnt;
  logic [CNT_W-1:0] cfg_lo;
  logic [CNT_W-1:0] cfg_hi;
  logic [PRE_W-1:0] cfg_pre;
  logic             scl_seen;
  logic             base_tick;
  logic             pre_clear;
  logic             pre_hold;
  logic [CNT_W-1:0] ph_next;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (scl_in),
    .q_sync  (scl_seen)
  );

  assign pre_clear = (phase == PH_OFF);
  assign pre_hold  = (phase == PH_HIGH) && !scl_seen;

  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pre_clear),
    .hold  (pre_hold),
    .limit (cfg_pre),
    .tick  (base_tick)
  );

  assign ph_next = ph_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_OFF;
      ph_cnt       <= '0;
      cfg_lo       <= low_ticks(RATIO_EVEN);
      cfg_hi       <= high_ticks(RATIO_EVEN);
      cfg_pre      <= '0;
      tick_fall    <= 1'b0;
      tick_mid_low <= 1'b0;
      tick_rise    <= 1'b0;
    end else begin
      tick_fall    <= 1'b0;
      tick_mid_low <= 1'b0;
      tick_rise    <= 1'b0;
      if (!enable) begin
        phase  <= PH_OFF;
        ph_cnt <= '0;
      end else begin
        case (phase)
          PH_OFF: begin
            phase     <= PH_LOW;
            ph_cnt    <= '0;
            cfg_lo    <= low_ticks(ratio_mode);
            cfg_hi    <= high_ticks(ratio_mode);
            cfg_pre   <= prescale;
            tick_fall <= 1'b1;
          end
          PH_LOW: begin
            if (base_tick) begin
              if (ph_next == cfg_lo) begin
                phase     <= PH_HIGH;
                ph_cnt    <= '0;
                tick_rise <= 1'b1;
              end else begin
                ph_cnt <= ph_next;
                if (ph_next == (cfg_lo >> 1)) tick_mid_low <= 1'b1;
              end
            end
          end
          PH_HIGH: begin
            if (base_tick) begin
              if (ph_next == cfg_hi) begin
                phase     <= PH_LOW;
                ph_cnt    <= '0;
                cfg_lo    <= low_ticks(ratio_mode);
                cfg_hi    <= high_ticks(ratio_mode);
                cfg_pre   <= prescale;
                tick_fall <= 1'b1;
              end else begin
                ph_cnt <= ph_next;
              end
            end
          end
          default: begin
            phase  <= PH_OFF;
            ph_cnt <= '0;
          end
        endcase
      end
    end
  end

  assign scl_drive_low = (phase == PH_LOW);

  assert_release_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_drive_low);

  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_fall, tick_mid_low, tick_rise}));

  assert_fall_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> scl_drive_low);

  assert_rise_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> !scl_drive_low);

  assert_mid_inside_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_mid_low |-> scl_drive_low);

  assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_HIGH && !scl_seen) |=> $stable(ph_cnt));

  assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW) |-> (ph_cnt < cfg_lo));

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic [PW-1:0] prescale;
  logic [1:0]    ratio_mode;
  logic          hold_low;
  logic          scl_in;
  logic          scl_drive_low, tick_fall, tick_mid_low, tick_rise;
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  assign scl_in = !scl_drive_low && !hold_low;

  scl_clock_gen #(.PRE_W(PW), .SYNC_STAGES(2)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .prescale      (prescale),
    .ratio_mode    (ratio_mode),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .tick_fall     (tick_fall),
    .tick_mid_low  (tick_mid_low),
    .tick_rise     (tick_rise)
  );

  function automatic int exp_lo(input int m);
    return (m == 1) ? 6 : (m == 2) ? 11 : 4;
  endfunction

  function automatic int exp_hi(input int m);
    return (m == 1 || m == 2) ? 3 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Starts at a negedge showing tick_fall, ends at the next such negedge.
  task automatic measure(input int lo, input int hi, input int p, input int s);
    int low = 0;
    int high = 0;
    int mid = -1;
    int mids = 0;
    while (scl_drive_low && low < 1000) begin
      if (tick_mid_low) begin mid = low; mids++; end
      low++;
      @(negedge clk);
    end
    chk(tick_rise == 1'b1, "R7 rise strobe", tick_rise, 1);
    while (!scl_drive_low && high < 1000) begin
      hold_low = (high < s);
      high++;
      @(negedge clk);
    end
    hold_low = 1'b0;
    chk(low == lo * (p + 1), "R2 R4 low length", low, lo * (p + 1));
    if (s > 0)
      chk(high == hi * (p + 1) + 2 + s, "R5 stretched high", high, hi * (p + 1) + 2 + s);
    else
      chk(high == hi * (p + 1) + 2, "R3 R4 high length", high, hi * (p + 1) + 2);
    chk(mid == (lo / 2) * (p + 1) && mids == 1, "R8 mid strobe", mid, (lo / 2) * (p + 1));
    chk(tick_fall == 1'b1, "R7 fall strobe", tick_fall, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; prescale = '0; ratio_mode = 2'd0; hold_low = 1'b0;
    repeat (3) @(negedge clk);
    chk({scl_drive_low, tick_fall, tick_mid_low, tick_rise} == 4'b0, "R1 reset outputs",
        {scl_drive_low, tick_fall, tick_mid_low, tick_rise}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R1 idle after reset", scl_drive_low, 0);

    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int si = 0; si < 2; si++) begin
          enable = 1'b0;
          prescale = PW'(p);
          ratio_mode = 2'(m);
          repeat (2) @(negedge clk);
          enable = 1'b1;
          @(negedge clk);
          chk(tick_fall == 1'b1 && scl_drive_low == 1'b1, "R6 start on enable", tick_fall, 1);
          measure(exp_lo(m), exp_hi(m), p, si * 3);
          measure(exp_lo(m), exp_hi(m), p, si * 3);
        end
      end
    end

    // R9: configuration change inside a period waits for the next low phase
    enable = 1'b0;
    prescale = PW'(1);
    ratio_mode = 2'd0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    ratio_mode = 2'd2;
    prescale = PW'(2);
    chk(tick_fall == 1'b1, "R9 period start", tick_fall, 1);
    measure(4, 4, 1, 0);
    measure(11, 3, 2, 0);

    // R6: disable in the middle of a low phase
    repeat (3) @(negedge clk);
    chk(scl_drive_low == 1'b1, "R6 inside low phase", scl_drive_low, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R6 release on disable", scl_drive_low, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        if (scl_drive_low || tick_fall || tick_mid_low || tick_rise) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R6 quiet while disabled", bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule